// File: doc/BRIEF.md
# Dual-Mode SD Card Clock Divider

This block derives the SD card clock from the core clock. An 11-bit divisor register holds the divide ratio minus two, so the card clock runs at core / (value + 2). The register resets to 507.

The block has two operating modes. In identification mode every bit of the divisor takes part in the ratio. In data mode only the three least significant bits count, which gives fast transfer clocks from one shared register. A slow-card configuration input keeps the full divisor in both modes. The mode follows two single-cycle pulses from the command logic. One pulse moves the block into data mode. The other returns it to identification mode.

The clock never stops; the slowest rate is reached with the largest divisor. A new ratio or mode is taken only at the start of a card-clock period, that is, at a falling edge. So no shortened high or low phase ever reaches the card. Strobes mark every rising and falling edge for the command and data shifters.

Top module: `cardclk_gen`

## Requirements
- R1: After reset, card_clk_o, rise_stb_o and fall_stb_o are low and data_mode_o is 0. The first period uses the reset divisor 507: 255 low core cycles followed by 254 high core cycles.
- R2: In identification mode the period is (divisor + 2) core cycles over all 11 bits. Divisor 0 gives 2 cycles and divisor 0x7FF gives 2049 cycles.
- R3: Every period starts with its low phase. For a ratio N the low phase lasts ceil(N/2) core cycles and the high phase lasts floor(N/2), so an odd ratio has the shorter high phase.
- R4: While data_mode_o is 1 and slow_card_i is 0, the period is (divisor[2:0] + 2) core cycles. Divisor bits 10:3 have no effect.
- R5: While slow_card_i is 1, the period is (divisor + 2) over all 11 bits, in data mode as well. The input is sampled when a period starts.
- R6: A pulse on enter_data_i requests data mode and a pulse on go_idle_i requests identification mode. If both arrive in the same cycle, identification mode wins. The requested mode appears on data_mode_o at the start of the next period.
- R7: A divisor write, a slow_card_i change or a mode request never alters the period in progress. data_mode_o changes only in a cycle where fall_stb_o is high.
- R8: rise_stb_o is high for exactly the first core cycle of each high phase. fall_stb_o is high for exactly the first core cycle of each low phase after the first. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_wr_i | input | 1 | Write strobe for the divisor register |
| div_wdata_i | input | 11 | New divisor value (ratio minus two) |
| slow_card_i | input | 1 | Keep the full divisor in every mode |
| enter_data_i | input | 1 | Pulse: request data mode |
| go_idle_i | input | 1 | Pulse: request identification mode |
| card_clk_o | output | 1 | Card clock |
| rise_stb_o | output | 1 | First core cycle of a card-clock high phase |
| fall_stb_o | output | 1 | First core cycle of a card-clock low phase |
| data_mode_o | output | 1 | Mode in force: 1 data, 0 identification |

## Verification
Two things can fall on the same core cycle. The first is a divisor write or mode pulse and the period boundary that would latch it. The second is an enter-data pulse and a go-idle pulse. Random bursts drive writes, pulses and slow-card toggles on arbitrary cycles, including the cycle just before a falling edge. A cycle-accurate bench model compares every output each cycle, so a change that lands one period early or late is caught. Directed cases fire both mode pulses in the same cycle and expect identification mode. A mid-period write must leave the current low and high counts at their old lengths.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;
  typedef enum logic {
    MODE_IDENT = 1'b0,
    MODE_DATA  = 1'b1
  } clk_mode_e;
endpackage

// File: rtl/cardclk_mode_ctl.sv
module cardclk_mode_ctl
  import cardclk_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enter_data_i,
  input  logic      go_idle_i,
  input  logic      period_end_i,
  output clk_mode_e mode_req_o,
  output clk_mode_e mode_act_o
);
  clk_mode_e req_q, act_q;

  // Requested mode: go-idle has priority over enter-data.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= MODE_IDENT;
    end else if (go_idle_i) begin
      req_q <= MODE_IDENT;
    end else if (enter_data_i) begin
      req_q <= MODE_DATA;
    end
  end

  // Applied mode moves only at a period boundary, i.e. at a falling edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= MODE_IDENT;
    end else if (period_end_i) begin
      act_q <= req_q;
    end
  end

  assign mode_req_o = req_q;
  assign mode_act_o = act_q;

  // R6: a go-idle pulse always leaves identification mode requested
  assert_idle_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    go_idle_i |=> (req_q == MODE_IDENT));

  // R7: the applied mode only moves after a period boundary
  assert_mode_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_q) |-> $past(period_end_i));
endmodule

// File: rtl/cardclk_phase_gen.sv
module cardclk_phase_gen #(
  parameter int RATIO_W     = 12,
  parameter int RESET_RATIO = 509
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio_next_i,
  output logic               period_end_o,
  output logic [RATIO_W-1:0] ratio_cur_o,
  output logic               card_clk_o,
  output logic               rise_o,
  output logic               fall_o
);
  // Low phase is the ceiling half, so an odd ratio has the shorter high phase.
  function automatic logic [RATIO_W-1:0] low_len(input logic [RATIO_W-1:0] n);
    return n - (n >> 1);
  endfunction

  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic [RATIO_W-1:0] ratio_q, ratio_d;
  logic               clk_q, clk_d;
  logic               rise_q, fall_q;

  assign period_end_o = (cnt_q == ratio_q - RATIO_W'(1));

  always_comb begin
    if (period_end_o) begin
      cnt_d   = '0;
      ratio_d = ratio_next_i;
    end else begin
      cnt_d   = cnt_q + RATIO_W'(1);
      ratio_d = ratio_q;
    end
    clk_d = (cnt_d >= low_len(ratio_d));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= RATIO_W'(RESET_RATIO);
      clk_q   <= 1'b0;
      rise_q  <= 1'b0;
      fall_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      clk_q   <= clk_d;
      rise_q  <= !clk_q && clk_d;
      fall_q  <= clk_q && !clk_d;
    end
  end

  assign ratio_cur_o = ratio_q;
  assign card_clk_o  = clk_q;
  assign rise_o      = rise_q;
  assign fall_o      = fall_q;

  // R8: the two strobes never coincide
  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_q && fall_q));

  // R8: the rise strobe marks the first high cycle
  assert_rise_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_q |-> (clk_q && !$past(clk_q)));

  // R8: the fall strobe marks the first low cycle
  assert_fall_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |-> (!clk_q && $past(clk_q)));

  // R7: the ratio in force changes only across a period boundary
  assert_ratio_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ratio_q) |-> $past(period_end_o));

  // R3: a new period always opens with the low phase
  assert_low_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    period_end_o |=> !clk_q);

  // R2: the ratio never drops below two
  assert_ratio_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_q >= RATIO_W'(2));
endmodule

// File: rtl/cardclk_gen.sv
module cardclk_gen
  import cardclk_pkg::*;
#(
  parameter int DIV_W     = 11,
  parameter int NARROW_W  = 3,
  parameter int RESET_DIV = 507
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_wr_i,
  input  logic [DIV_W-1:0] div_wdata_i,
  input  logic             slow_card_i,
  input  logic             enter_data_i,
  input  logic             go_idle_i,
  output logic             card_clk_o,
  output logic             rise_stb_o,
  output logic             fall_stb_o,
  output logic             data_mode_o
);
  localparam int RATIO_W     = DIV_W + 1;
  localparam int RESET_RATIO = RESET_DIV + 2;

  // Stored value is ratio minus two; narrow mode keeps only the low bits.
  function automatic logic [RATIO_W-1:0] eff_ratio(input logic [DIV_W-1:0] dv,
                                                  input logic narrow);
    logic [RATIO_W-1:0] base;
    base = narrow ? RATIO_W'(dv[NARROW_W-1:0]) : RATIO_W'(dv);
    return base + RATIO_W'(2);
  endfunction

  logic [DIV_W-1:0]   div_q;
  clk_mode_e          mode_req, mode_act;
  logic               period_end;
  logic               use_narrow;
  logic [RATIO_W-1:0] ratio_next;
  logic [RATIO_W-1:0] ratio_cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= DIV_W'(RESET_DIV);
    end else if (div_wr_i) begin
      div_q <= div_wdata_i;
    end
  end

  assign use_narrow = (mode_req == MODE_DATA) && !slow_card_i;
  assign ratio_next = eff_ratio(div_q, use_narrow);

  cardclk_mode_ctl u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .enter_data_i (enter_data_i),
    .go_idle_i    (go_idle_i),
    .period_end_i (period_end),
    .mode_req_o   (mode_req),
    .mode_act_o   (mode_act)
  );

  cardclk_phase_gen #(
    .RATIO_W     (RATIO_W),
    .RESET_RATIO (RESET_RATIO)
  ) u_phase (
    .clk          (clk),
    .rst_n        (rst_n),
    .ratio_next_i (ratio_next),
    .period_end_o (period_end),
    .ratio_cur_o  (ratio_cur),
    .card_clk_o   (card_clk_o),
    .rise_o       (rise_stb_o),
    .fall_o       (fall_stb_o)
  );

  assign data_mode_o = (mode_act == MODE_DATA);

  // R7: the visible mode flips only together with a falling edge
  assert_mode_with_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_mode_o) |-> fall_stb_o);

  // R4: a period opened in data mode without slow-card stays within the narrow range
  assert_narrow_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (period_end && use_narrow) |=> (ratio_cur <= RATIO_W'((1 << NARROW_W) + 1)));
endmodule

// File: tb/tb_cardclk_gen.sv
module tb_cardclk_gen;
  localparam int DIV_W = 11;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             div_wr = 1'b0;
  logic [DIV_W-1:0] div_wdata = '0;
  logic             slow_card = 1'b0;
  logic             enter_data = 1'b0;
  logic             go_idle = 1'b0;
  logic             card_clk, rise_stb, fall_stb, data_mode;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cardclk_gen dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .div_wr_i     (div_wr),
    .div_wdata_i  (div_wdata),
    .slow_card_i  (slow_card),
    .enter_data_i (enter_data),
    .go_idle_i    (go_idle),
    .card_clk_o   (card_clk),
    .rise_stb_o   (rise_stb),
    .fall_stb_o   (fall_stb),
    .data_mode_o  (data_mode)
  );

  // Bench restatement of the requirements: period length and half split.
  function automatic int ratio_of(input int dv, input bit dmode, input bit slow);
    if (dmode && !slow) return (dv % 8) + 2;
    return dv + 2;
  endfunction
  function automatic int low_of(input int n);
    return (n + 1) / 2;
  endfunction

  // Cycle model built from R1..R8.
  int m_cnt, m_ratio, m_div;
  bit m_req, m_mode, m_clk, m_rise, m_fall;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_ratio = 509; m_div = 507;
      m_req = 0; m_mode = 0; m_clk = 0; m_rise = 0; m_fall = 0;
    end else begin
      bit old_clk, nclk;
      old_clk = m_clk;
      if (m_cnt == m_ratio - 1) begin
        m_cnt   = 0;
        m_ratio = ratio_of(m_div, m_req, slow_card);
        m_mode  = m_req;
      end else begin
        m_cnt = m_cnt + 1;
      end
      nclk   = (m_cnt >= low_of(m_ratio));
      m_rise = !old_clk && nclk;
      m_fall = old_clk && !nclk;
      m_clk  = nclk;
      if (go_idle) m_req = 0;
      else if (enter_data) m_req = 1;
      if (div_wr) m_div = int'(div_wdata);
    end
  end

  task automatic check_val(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    check_val(card_clk, m_clk, "R3 card_clk vs model");
    check_val(rise_stb, m_rise, "R8 rise_stb vs model");
    check_val(fall_stb, m_fall, "R8 fall_stb vs model");
    check_val(data_mode, m_mode, "R6 data_mode vs model");
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
  endtask

  task automatic sync_fall();
    do tick(); while (!fall_stb);
  endtask

  task automatic measure(output int lo, output int hi);
    lo = 0; hi = 0;
    while (card_clk == 1'b0) begin lo++; tick(); end
    while (card_clk == 1'b1) begin hi++; tick(); end
  endtask

  task automatic write_div(input int v);
    div_wdata = DIV_W'(v); div_wr = 1'b1;
    tick();
    div_wr = 1'b0;
  endtask

  task automatic pulse(input bit ent, input bit idl);
    enter_data = ent; go_idle = idl;
    tick();
    enter_data = 1'b0; go_idle = 1'b0;
  endtask

  task automatic expect_period(input int n, input string tag);
    int lo, hi;
    measure(lo, hi);
    check_val(lo, low_of(n), {tag, " low phase"});
    check_val(hi, n / 2, {tag, " high phase"});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lo, hi, v;
    void'($urandom(32'h5D1C_0A7E));
    repeat (3) @(negedge clk);
    // R1: reset state
    check_val(card_clk, 0, "R1 card_clk in reset");
    check_val(rise_stb, 0, "R1 rise_stb in reset");
    check_val(fall_stb, 0, "R1 fall_stb in reset");
    check_val(data_mode, 0, "R1 data_mode in reset");
    rst_n = 1'b1;
    expect_period(509, "R1 first period");

    // R2: smallest and largest identification ratios
    write_div(0); sync_fall();
    expect_period(2, "R2 div 0");
    write_div(11'h7FF); sync_fall();
    expect_period(2049, "R2 div 0x7FF");

    // R3: odd ratio 9
    write_div(7); sync_fall();
    expect_period(9, "R3 odd ratio");

    // R7: a mid-period write leaves the running period alone
    write_div(0);
    lo = 1; hi = 0;
    while (card_clk == 1'b0) begin lo++; tick(); end
    while (card_clk == 1'b1) begin hi++; tick(); end
    check_val(lo, 5, "R7 running low phase");
    check_val(hi, 4, "R7 running high phase");
    expect_period(2, "R7 new value next period");

    // R4 / R6: data mode narrow divisor
    write_div(11'h7FD);
    pulse(1'b1, 1'b0); sync_fall();
    check_val(data_mode, 1, "R6 enter data mode");
    expect_period(7, "R4 narrow bits only");

    // R5: slow-card keeps the full divisor in data mode
    write_div(11'h0F3);
    slow_card = 1'b1; tick(); sync_fall();
    expect_period(245, "R5 slow card full divisor");
    slow_card = 1'b0; tick(); sync_fall();
    expect_period(5, "R4 narrow after slow off");

    // R6: both pulses in one cycle -> identification mode
    pulse(1'b1, 1'b1); sync_fall();
    check_val(data_mode, 0, "R6 idle wins on collision");
    expect_period(245, "R6 ident ratio after collision");
    pulse(1'b0, 1'b1); sync_fall();
    check_val(data_mode, 0, "R6 go idle from ident");

    // Random bursts against the cycle model
    for (int it = 0; it < 30; it++) begin
      int len;
      len = 1 + ($urandom % 300);
      for (int c = 0; c < len; c++) begin
        div_wr = ($urandom % 16) == 0;
        v = (($urandom % 2) == 0) ? ($urandom % 16) : ($urandom % 512);
        div_wdata = DIV_W'(v);
        enter_data = ($urandom % 32) == 0;
        go_idle = ($urandom % 32) == 0;
        if (($urandom % 64) == 0) slow_card = !slow_card;
        tick();
      end
      div_wr = 1'b0; enter_data = 1'b0; go_idle = 1'b0;
      tick(); sync_fall();
      expect_period(m_ratio, "R2 R4 R5 random period");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule